// File: doc/BRIEF.md
# Tri-State Sample Clock Gate

This block makes the sample clock for a capture engine. A controlling processor sets it with a single command. The clock can be parked low, parked high, or left to run at half the rate of a fast reference clock. The reference is a doubled copy of the oscillator. So in run mode the output reproduces the oscillator, and every edge of the output comes from one flip-flop clocked on the clean edge of the reference. Because of that, the output has no partial pulses or glitches in any state or during any change of state.

The processor uses the same output for two jobs. First, it shifts configuration words into the capture logic by stepping the clock one edge at a time: it moves between the parked-low and parked-high commands. Second, it paces slow-timebase sampling by starting and stopping the free run. The tri-state control pin is modelled as a 2-bit command, and the command is resampled through a short synchroniser before it is used.

Top module: `tristate_clk_gate`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the register behind `sclk_o` is cleared, so `sclk_o` is 0 from the following edge. After reset the gate is in the parked-low state.
- R2: Command code 2'b00 parks the output low: `sclk_o` stays 0 on every edge for as long as that command is in force.
- R3: Command code 2'b01 parks the output high: `sclk_o` stays 1 on every edge for as long as that command is in force.
- R4: Command codes 2'b10 and 2'b11 both select free run, in which `sclk_o` inverts on every rising edge of `clk`. The period is two reference cycles.
- R5: A command placed on `cmd_i` first shows at `sclk_o` on the (SYNC_STAGES+1)-th rising edge of `clk` after it is applied. With the default of 2 stages, that is the third edge.
- R6: Entering free run from parked low begins with a full high half-period. Entering free run from parked high begins with a full low half-period. No high or low phase of `sclk_o` is ever shorter than one reference cycle.
- R7: Each move from code 2'b00 to 2'b01 gives exactly one rising edge on `sclk_o`. The move back gives no rising edge.
- R8: Leaving free run for a parked code drives `sclk_o` to the parked level on the edge where the command takes effect, and the output then shows no further edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Doubled reference clock (twice the oscillator rate) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Gate command: 00 park low, 01 park high, 1x run |
| sclk_o | output | 1 | Gated sample clock, registered |

## Verification
A wrong synchroniser depth shows at the port as a command that takes effect one edge early or one edge late. The bench looks for the first change exactly on the (SYNC_STAGES+1)-th edge. A fault in the mode decode shows within that same latency: the output is at the wrong static level, or it fails to toggle for one of the two run codes. A fault in the output stage shows as a missing or extra rising edge when the bench counts edges during single-stepping. It also shows as the wrong first phase on entry to free run, which is visible on the first edge after the latency.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  localparam int CMD_W = 2;

  typedef enum logic [1:0] {
    GATE_LOW  = 2'd0,
    GATE_HIGH = 2'd1,
    GATE_RUN  = 2'd2
  } gate_mode_e;

  function automatic gate_mode_e decode_cmd(input logic [CMD_W-1:0] c);
    if (c[1])      return GATE_RUN;
    else if (c[0]) return GATE_HIGH;
    else           return GATE_LOW;
  endfunction

endpackage

// File: rtl/tcg_cmd_sync.sv
module tcg_cmd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/tcg_mode_dec.sv
module tcg_mode_dec
  import tcg_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output gate_mode_e       mode_o
);

  always_comb mode_o = decode_cmd(cmd_i);

endmodule

// File: rtl/tcg_out_stage.sv
module tcg_out_stage
  import tcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  gate_mode_e mode_i,
  output logic       sclk_o
);

  logic nxt;

  // Every change lands on a reference edge, so each phase lasts >= 1 cycle.
  always_comb begin
    unique case (mode_i)
      GATE_HIGH: nxt = 1'b1;
      GATE_RUN:  nxt = ~sclk_o;
      default:   nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_o <= 1'b0;
    else     sclk_o <= nxt;
  end

endmodule

// File: rtl/tristate_clk_gate.sv
module tristate_clk_gate
  import tcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             sclk_o
);

  localparam int STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [CMD_W-1:0] cmd_sync;
  gate_mode_e       mode;

  tcg_cmd_sync #(.W(CMD_W), .STAGES(STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmd_i),
    .q_o (cmd_sync)
  );

  tcg_mode_dec u_dec (
    .cmd_i  (cmd_sync),
    .mode_o (mode)
  );

  tcg_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode),
    .sclk_o (sclk_o)
  );

endmodule

// File: rtl/tristate_clk_gate_chk.sv
module tristate_clk_gate_chk
  import tcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [CMD_W-1:0] cmd_i,
  input logic             sclk_o
);

  localparam int STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  // Independent delay line of the command as seen at the port.
  logic [CMD_W-1:0] dly [STG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STG; i++) dly[i] <= '0;
    end else begin
      dly[0] <= cmd_i;
      for (int i = 1; i < STG; i++) dly[i] <= dly[i-1];
    end
  end

  logic [CMD_W-1:0] eff;
  assign eff = dly[STG-1];

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !sclk_o)
    else $error("R1 output not low after reset");

  p_park_low_r2: assert property (@(posedge clk) disable iff (rst)
    (eff == 2'b00) |=> !sclk_o)
    else $error("R2 parked-low output went high");

  p_park_high_r3: assert property (@(posedge clk) disable iff (rst)
    (eff == 2'b01) |=> sclk_o)
    else $error("R3 parked-high output went low");

  p_run_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    eff[1] |=> (sclk_o != $past(sclk_o)))
    else $error("R4 run output failed to toggle");

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> ($past(eff) != 2'b00))
    else $error("R7 rising edge while parked low");

  p_exit_run_r8: assert property (@(posedge clk) disable iff (rst)
    ((eff == 2'b00) && $past(eff[1])) |=> !sclk_o)
    else $error("R8 run exit did not settle low");

endmodule

bind tristate_clk_gate tristate_clk_gate_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cmd_i  (cmd_i),
  .sclk_o (sclk_o)
);

// File: tb/tristate_clk_gate_test.sv
`timescale 1ns/1ps
module tristate_clk_gate_test;

  localparam int SYNC_STAGES = 2;
  localparam int LAT = SYNC_STAGES + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic       sclk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tristate_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) uut (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd),
    .sclk_o (sclk)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(logic [1:0] c);
    cmd = c;
    for (int i = 0; i < LAT + 2; i++) tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cmd = 2'b01;
    for (int i = 0; i < 3; i++) tick();
    chk("R1 low during reset", sclk, 1'b0);
    cmd = 2'b00;
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R1 parked low after reset", sclk, 1'b0);
    end
  endtask

  task automatic t_park_low();
    settle(2'b01);
    cmd = 2'b00;
    for (int i = 0; i < LAT; i++) tick();
    for (int i = 0; i < 6; i++) begin
      chk("R2 parked low", sclk, 1'b0);
      tick();
    end
  endtask

  task automatic t_park_high();
    settle(2'b00);
    cmd = 2'b01;
    for (int i = 0; i < LAT; i++) tick();
    for (int i = 0; i < 6; i++) begin
      chk("R3 parked high", sclk, 1'b1);
      tick();
    end
  endtask

  task automatic t_run(logic [1:0] code);
    logic exp;
    settle(2'b00);
    cmd = code;
    for (int i = 0; i < LAT; i++) tick();
    exp = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R4 run toggles each cycle", sclk, exp);
      exp = ~exp;
      tick();
    end
  endtask

  task automatic t_latency();
    settle(2'b00);
    cmd = 2'b01;
    for (int i = 0; i < LAT - 1; i++) tick();
    chk("R5 no change before latency", sclk, 1'b0);
    tick();
    chk("R5 change exactly at latency", sclk, 1'b1);
    cmd = 2'b00;
    for (int i = 0; i < LAT - 1; i++) tick();
    chk("R5 no fall before latency", sclk, 1'b1);
    tick();
    chk("R5 fall exactly at latency", sclk, 1'b0);
  endtask

  task automatic t_run_entry_high();
    settle(2'b01);
    cmd = 2'b10;
    for (int i = 0; i < LAT; i++) tick();
    chk("R6 run from high starts low", sclk, 1'b0);
    tick();
    chk("R6 first low phase one cycle", sclk, 1'b1);
    tick();
    chk("R6 first high phase one cycle", sclk, 1'b0);
  endtask

  task automatic t_single_step();
    int rises = 0;
    logic prev;
    settle(2'b00);
    prev = sclk;
    for (int n = 0; n < 5; n++) begin
      cmd = 2'b01;
      for (int i = 0; i < LAT + 2; i++) begin
        tick();
        if (sclk && !prev) rises++;
        prev = sclk;
      end
      cmd = 2'b00;
      for (int i = 0; i < LAT + 2; i++) begin
        tick();
        if (sclk && !prev) rises++;
        prev = sclk;
      end
    end
    chk_int("R7 one rise per step", rises, 5);
  endtask

  task automatic t_run_exit(logic [1:0] park, logic lvl);
    settle(2'b11);
    cmd = park;
    for (int i = 0; i < LAT; i++) tick();
    for (int i = 0; i < 5; i++) begin
      chk("R8 run exit parked level", sclk, lvl);
      tick();
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_park_low();
    t_park_high();
    t_run(2'b10);
    t_run(2'b11);
    t_latency();
    t_run_entry_high();
    t_single_step();
    t_run_exit(2'b00, 1'b0);
    t_run_exit(2'b01, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule